// File: doc/BRIEF.md
# Three-Wire Handshaked Packet Link Master

This block is the host end of a half-duplex packet link to a peripheral microcontroller. Bytes cross the link through an external shift register. The block drives the register's direction and load strobe, and reacts to its shift-complete pulse. Two host-driven framing lines mark a frame in progress (active low) and acknowledge each byte by toggling. The peripheral answers on one active-low request line. The block samples that line as a level.

An outbound packet arrives as a byte stream on a valid/ready port. The first byte is the packet type, and a last flag closes the packet. The whole packet is held until it has gone out. Inbound frames leave as a byte stream with a last flag, an overflow flag and a payload length.

If the peripheral raises its request while the host is writing, the host stops the write. It takes the byte that just shifted as the type byte of an incoming frame and keeps the packet pending. After the inbound frame ends, it waits a guard time and then sends the packet again from its first byte. All waits come from a cycle timer that is scaled from the clock frequency.

Top module: `serlink_master`

## Requirements
- R1: While reset is asserted, both framing lines (`linkTipN`, `linkAck`) are high, `srDirOut` is 0 (input), and `txReady`, `rxValid` and `srLoad` are 0.
- R2: After reset the block runs a wake-up sequence on the framing lines, one step every SETTLE cycles: frame line low, acknowledge low, frame line high, acknowledge high. `txReady` rises in the cycle the last step occurs.
- R3: With the bus idle, a packet pending and `linkReqN` high, the block starts a write in a single cycle. It sets `srDirOut` to 1, pulses `srLoad` with the type byte, holds `linkAck` high and pulls `linkTipN` low.
- R4: Each shift-complete during a write loads the next stored byte and inverts `linkAck`. The shift-complete of the final byte instead returns both lines high and `srDirOut` to 0, and raises `txReady` again.
- R5: No write starts while `linkReqN` is low.
- R6: A shift-complete in idle with `linkReqN` low emits the shifted byte as the type byte (`rxLast`=0), pulls `linkTipN` low and keeps `srDirOut` at 0. The same pulse with `linkReqN` high emits nothing and leaves the lines unchanged.
- R7: During a receive, a shift-complete with `linkReqN` still low emits the byte and inverts `linkAck`. With `linkReqN` high, the byte is emitted with `rxLast`=1 and `rxLen` equal to the number of bytes after the type byte, and both lines return high.
- R8: The byte that brings a frame to MAX_RX bytes (type byte included) while `linkReqN` is still low ends the frame. It is emitted with `rxLast`=1 and `rxErr`=1.
- R9: A shift-complete during a write with `linkReqN` low aborts the write. The shifted byte is emitted as a type byte, `linkTipN` stays low, `linkAck` goes high, `srDirOut` goes to 0, and the packet stays pending.
- R10: When an inbound frame ends with a packet pending and `linkReqN` high, the write restarts from the type byte exactly GUARD cycles after the frame's last byte.
- R11: If `linkReqN` is low when the guard time expires, no write starts and the lines stay high. The next inbound frame is received, and the write follows a guard time after that frame.
- R12: The TX_DEPTH-th byte of an outbound packet closes the packet even if `txLast` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txValid | input | 1 | Outbound byte valid |
| txData | input | 8 | Outbound byte (first byte of a packet is its type) |
| txLast | input | 1 | Marks the final outbound byte |
| txReady | output | 1 | Block can take an outbound byte |
| rxValid | output | 1 | Inbound byte strobe |
| rxData | output | 8 | Inbound byte |
| rxLast | output | 1 | Inbound byte ends the frame |
| rxErr | output | 1 | Frame ended by overflow |
| rxLen | output | $clog2(MAX_RX+1) | Payload byte count, valid with rxLast |
| srDone | input | 1 | Shift register finished a byte |
| srRdData | input | 8 | Byte read from the shift register |
| srLoad | output | 1 | Load strobe for the shift register |
| srWrData | output | 8 | Byte to load |
| srDirOut | output | 1 | Shift direction, 1 = output |
| linkTipN | output | 1 | Frame-in-progress line, active low |
| linkAck | output | 1 | Acknowledge toggle line |
| linkReqN | input | 1 | Peripheral request, active low |

## Verification
Every reaction to a shift-complete is registered once. A load, an inbound byte or a line change caused by a pulse at a clock edge shows up at the next falling edge, and the bench samples exactly there. The wake-up steps are timed from one falling edge to the next and must each be SETTLE cycles apart. The restart after a guard time is counted from the falling edge after the frame's last byte to the falling edge where `srLoad` is seen, and must equal GUARD. A scoreboard pairs every expected load and every expected inbound byte with the pulse that produced it.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

  typedef enum logic [2:0] {
    S_INIT,
    S_IDLE,
    S_TX,
    S_RX,
    S_GUARD
  } linkState_t;

  typedef struct packed {
    logic sendStart;
    logic sendNext;
    logic sendDone;
    logic sendAbort;
    logic rxFirst;
    logic rxByte;
    logic rxEnd;
    logic rxOvf;
  } linkStrobe_t;

endpackage

// File: rtl/serlink_data.sv
module serlink_data
  import serlink_pkg::*;
#(
  parameter int TX_DEPTH = 16,
  parameter int MAX_RX   = 256,
  localparam int AW = $clog2(TX_DEPTH),
  localparam int PW = $clog2(TX_DEPTH + 1),
  localparam int CW = $clog2(MAX_RX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          linkReady,
  input  logic          txValid,
  input  logic [7:0]    txData,
  input  logic          txLast,
  output logic          txReady,
  input  logic [7:0]    srRdData,
  input  linkStrobe_t   stb,
  output logic          pending,
  output logic          lastSent,
  output logic          rcvFull,
  output logic          srLoad,
  output logic [7:0]    srWrData,
  output logic          rxValid,
  output logic [7:0]    rxData,
  output logic          rxLast,
  output logic          rxErr,
  output logic [CW-1:0] rxLen
);

  logic [7:0]    txBuf [TX_DEPTH];
  logic [AW-1:0] wrPtr;
  logic [PW-1:0] txLen;
  logic [PW-1:0] sentCnt;
  logic [PW-1:0] sentInc;
  logic [CW-1:0] rcvCnt;
  logic          txFire;
  logic          closePkt;

  assign txReady  = linkReady && !pending;
  assign txFire   = txValid && txReady;
  assign closePkt = txLast || (wrPtr == AW'(TX_DEPTH - 1));
  assign sentInc  = sentCnt + PW'(1);
  assign lastSent = (sentInc == txLen);
  assign rcvFull  = (rcvCnt == CW'(MAX_RX - 1));

  always_ff @(posedge clk) begin
    if (txFire) txBuf[wrPtr] <= txData;
  end

  // outbound packet capture and replay pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      txLen    <= '0;
      pending  <= 1'b0;
      sentCnt  <= '0;
      srLoad   <= 1'b0;
      srWrData <= '0;
    end else begin
      srLoad <= stb.sendStart || stb.sendNext;
      if (txFire) begin
        if (closePkt) begin
          pending <= 1'b1;
          txLen   <= PW'(wrPtr) + PW'(1);
          wrPtr   <= '0;
        end else begin
          wrPtr <= wrPtr + AW'(1);
        end
      end
      if (stb.sendStart) begin
        sentCnt  <= '0;
        srWrData <= txBuf[0];
      end else if (stb.sendNext) begin
        sentCnt  <= sentInc;
        srWrData <= txBuf[AW'(sentInc)];
      end
      if (stb.sendAbort) sentCnt <= '0;
      if (stb.sendDone) begin
        pending <= 1'b0;
        sentCnt <= '0;
      end
    end
  end

  // inbound byte stream
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rcvCnt  <= '0;
      rxValid <= 1'b0;
      rxData  <= '0;
      rxLast  <= 1'b0;
      rxErr   <= 1'b0;
      rxLen   <= '0;
    end else begin
      rxValid <= stb.rxFirst || stb.rxByte;
      rxLast  <= stb.rxEnd;
      rxErr   <= stb.rxOvf;
      if (stb.rxFirst || stb.rxByte) rxData <= srRdData;
      if (stb.rxFirst) begin
        rcvCnt <= CW'(1);
      end else if (stb.rxByte) begin
        rxLen  <= rcvCnt;
        rcvCnt <= stb.rxEnd ? '0 : rcvCnt + CW'(1);
      end
    end
  end

  p_load_needs_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    srLoad |-> pending);
  p_rcv_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    rcvCnt <= CW'(MAX_RX));
  p_err_is_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxErr) |-> rxLast);
  p_no_take_when_pending_r12: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> (wrPtr == $past(wrPtr)));

endmodule

// File: rtl/serlink_ctrl.sv
module serlink_ctrl
  import serlink_pkg::*;
#(
  parameter int SETTLE_CYC = 18750,
  parameter int GUARD_CYC  = 187500,
  localparam int MAXC = (SETTLE_CYC > GUARD_CYC) ? SETTLE_CYC : GUARD_CYC,
  localparam int TW   = $clog2(MAXC + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        srDone,
  input  logic        reqN,
  input  logic        pending,
  input  logic        lastSent,
  input  logic        rcvFull,
  output linkStrobe_t stb,
  output logic        linkReady,
  output logic        tipN,
  output logic        ackOut,
  output logic        dirOut
);

  linkState_t    state, stateNext;
  logic [1:0]    phase, phaseNext;
  logic [TW-1:0] timer, timerNext;
  logic          tipNext, ackNext, dirNext;

  assign linkReady = (state != S_INIT);

  always_comb begin
    stb       = '0;
    stateNext = state;
    phaseNext = phase;
    timerNext = timer;
    tipNext   = tipN;
    ackNext   = ackOut;
    dirNext   = dirOut;
    unique case (state)
      S_INIT: begin
        if (timer == '0) begin
          timerNext = TW'(SETTLE_CYC - 1);
          phaseNext = phase + 2'd1;
          unique case (phase)
            2'd0: tipNext = 1'b0;
            2'd1: ackNext = 1'b0;
            2'd2: tipNext = 1'b1;
            default: begin
              ackNext   = 1'b1;
              stateNext = S_IDLE;
            end
          endcase
        end else begin
          timerNext = timer - TW'(1);
        end
      end
      S_IDLE: begin
        if (srDone && !reqN) begin
          stb.rxFirst = 1'b1;
          stateNext   = S_RX;
          tipNext     = 1'b0;
          ackNext     = 1'b1;
          dirNext     = 1'b0;
        end else if (pending && reqN) begin
          stb.sendStart = 1'b1;
          stateNext     = S_TX;
          tipNext       = 1'b0;
          ackNext       = 1'b1;
          dirNext       = 1'b1;
        end
      end
      S_TX: begin
        if (srDone) begin
          if (!reqN) begin
            stb.sendAbort = 1'b1;
            stb.rxFirst   = 1'b1;
            stateNext     = S_RX;
            tipNext       = 1'b0;
            ackNext       = 1'b1;
            dirNext       = 1'b0;
          end else if (lastSent) begin
            stb.sendDone = 1'b1;
            stateNext    = S_IDLE;
            tipNext      = 1'b1;
            ackNext      = 1'b1;
            dirNext      = 1'b0;
          end else begin
            stb.sendNext = 1'b1;
            ackNext      = !ackOut;
          end
        end
      end
      S_RX: begin
        if (srDone) begin
          stb.rxByte = 1'b1;
          if (reqN || rcvFull) begin
            stb.rxEnd = 1'b1;
            stb.rxOvf = !reqN;
            tipNext   = 1'b1;
            ackNext   = 1'b1;
            dirNext   = 1'b0;
            if (pending) begin
              stateNext = S_GUARD;
              timerNext = TW'(GUARD_CYC - 1);
            end else begin
              stateNext = S_IDLE;
            end
          end else begin
            ackNext = !ackOut;
          end
        end
      end
      S_GUARD: begin
        if (timer == '0) begin
          if (reqN) begin
            stb.sendStart = 1'b1;
            stateNext     = S_TX;
            tipNext       = 1'b0;
            ackNext       = 1'b1;
            dirNext       = 1'b1;
          end else begin
            stateNext = S_IDLE;
          end
        end else begin
          timerNext = timer - TW'(1);
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_INIT;
      phase  <= 2'd0;
      timer  <= TW'(SETTLE_CYC - 1);
      tipN   <= 1'b1;
      ackOut <= 1'b1;
      dirOut <= 1'b0;
    end else begin
      state  <= stateNext;
      phase  <= phaseNext;
      timer  <= timerNext;
      tipN   <= tipNext;
      ackOut <= ackNext;
      dirOut <= dirNext;
    end
  end

  p_idle_lines_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (tipN && ackOut && !dirOut));
  p_tx_lines_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX) |-> (!tipN && dirOut));
  p_rx_lines_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX) |-> (!tipN && !dirOut));
  p_ack_toggle_tx_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX && srDone && reqN && !lastSent) |=> (ackOut != $past(ackOut)));
  p_ack_toggle_rx_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RX && srDone && !reqN && !rcvFull) |=> (ackOut != $past(ackOut)));
  p_collision_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX && srDone && !reqN) |=> (state == S_RX && !tipN && ackOut && pending));
  p_no_start_req_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sendStart) |-> reqN);

endmodule

// File: rtl/serlink_master.sv
module serlink_master #(
  parameter int CLK_KHZ   = 125000,
  parameter int SETTLE_US = 150,
  parameter int GUARD_US  = 1500,
  parameter int TX_DEPTH  = 16,
  parameter int MAX_RX    = 256,
  localparam int SETTLE_RAW = CLK_KHZ * SETTLE_US / 1000,
  localparam int GUARD_RAW  = CLK_KHZ * GUARD_US / 1000,
  localparam int SETTLE_CYC = (SETTLE_RAW < 1) ? 1 : SETTLE_RAW,
  localparam int GUARD_CYC  = (GUARD_RAW < 1) ? 1 : GUARD_RAW,
  localparam int LW = $clog2(MAX_RX + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          txValid,
  input  logic [7:0]    txData,
  input  logic          txLast,
  output logic          txReady,
  output logic          rxValid,
  output logic [7:0]    rxData,
  output logic          rxLast,
  output logic          rxErr,
  output logic [LW-1:0] rxLen,
  input  logic          srDone,
  input  logic [7:0]    srRdData,
  output logic          srLoad,
  output logic [7:0]    srWrData,
  output logic          srDirOut,
  output logic          linkTipN,
  output logic          linkAck,
  input  logic          linkReqN
);

  serlink_pkg::linkStrobe_t stb;
  logic linkReady, pending, lastSent, rcvFull;

  serlink_ctrl #(
    .SETTLE_CYC(SETTLE_CYC),
    .GUARD_CYC (GUARD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .srDone   (srDone),
    .reqN     (linkReqN),
    .pending  (pending),
    .lastSent (lastSent),
    .rcvFull  (rcvFull),
    .stb      (stb),
    .linkReady(linkReady),
    .tipN     (linkTipN),
    .ackOut   (linkAck),
    .dirOut   (srDirOut)
  );

  serlink_data #(
    .TX_DEPTH(TX_DEPTH),
    .MAX_RX  (MAX_RX)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .linkReady(linkReady),
    .txValid  (txValid),
    .txData   (txData),
    .txLast   (txLast),
    .txReady  (txReady),
    .srRdData (srRdData),
    .stb      (stb),
    .pending  (pending),
    .lastSent (lastSent),
    .rcvFull  (rcvFull),
    .srLoad   (srLoad),
    .srWrData (srWrData),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .rxLast   (rxLast),
    .rxErr    (rxErr),
    .rxLen    (rxLen)
  );

endmodule

// File: tb/serlink_master_bench.sv
module serlink_master_bench;

  localparam int TX_DEPTH   = 4;
  localparam int MAX_RX     = 6;
  localparam int SETTLE_CYC = 4;   // CLK_KHZ=1000, SETTLE_US=4
  localparam int GUARD_CYC  = 20;  // CLK_KHZ=1000, GUARD_US=20
  localparam int LW = $clog2(MAX_RX + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txValid = 1'b0, txLast = 1'b0;
  logic [7:0] txData = '0;
  logic txReady, rxValid, rxLast, rxErr;
  logic [7:0] rxData;
  logic [LW-1:0] rxLen;
  logic srDone = 1'b0;
  logic [7:0] srRdData = '0;
  logic srLoad, srDirOut, linkTipN, linkAck;
  logic [7:0] srWrData;
  logic linkReqN = 1'b1;

  always #4 clk = ~clk;  // 125 MHz

  serlink_master #(
    .CLK_KHZ(1000), .SETTLE_US(4), .GUARD_US(20),
    .TX_DEPTH(TX_DEPTH), .MAX_RX(MAX_RX)
  ) u_serlink_master (
    .clk(clk), .rstN(rstN),
    .txValid(txValid), .txData(txData), .txLast(txLast), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxLast(rxLast), .rxErr(rxErr), .rxLen(rxLen),
    .srDone(srDone), .srRdData(srRdData), .srLoad(srLoad), .srWrData(srWrData),
    .srDirOut(srDirOut), .linkTipN(linkTipN), .linkAck(linkAck), .linkReqN(linkReqN)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  logic [7:0]  txQ[$];
  logic [17:0] rxQ[$];  // {err, last, len, data}

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finishSim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (srLoad) begin
        if (txQ.size() == 0) checkEq({curReq, " unexpected load"}, int'(srWrData), -1);
        else checkEq({curReq, " loaded byte"}, int'(srWrData), int'(txQ.pop_front()));
      end
      if (rxValid) begin
        logic [17:0] act;
        act = {rxErr, rxLast, rxLast ? 8'(rxLen) : 8'h00, rxData};
        if (rxQ.size() == 0) checkEq({curReq, " unexpected inbound byte"}, int'(act), -1);
        else checkEq({curReq, " inbound byte"}, int'(act), int'(rxQ.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishSim();
  end

  task automatic sendPacket(input logic [7:0] pk [4], input int n, input bit useLast);
    for (int i = 0; i < n; i++) begin
      txQ.push_back(pk[i]);
      @(negedge clk);
      while (!txReady) @(negedge clk);
      txValid = 1'b1; txData = pk[i]; txLast = useLast && (i == n - 1);
      @(negedge clk);
      txValid = 1'b0; txLast = 1'b0;
    end
  endtask

  task automatic waitLoad();
    while (!srLoad) @(negedge clk);
  endtask

  task automatic pulseDone(input logic [7:0] d, input logic rq);
    srRdData = d; linkReqN = rq; srDone = 1'b1;
    @(negedge clk);
    srDone = 1'b0;
  endtask

  task automatic pushRx(input bit err, input bit last, input int len, input logic [7:0] d);
    rxQ.push_back({err, last, 8'(len), d});
  endtask

  task automatic servWrite(input int n);
    logic prevAck;
    prevAck = 1'b1;
    for (int i = 0; i < n; i++) begin
      waitLoad();
      if (i == 0) begin
        checkEq("R3 ack high at start", int'(linkAck), 1);
        checkEq("R3 frame line low", int'(linkTipN), 0);
        checkEq("R3 direction out", int'(srDirOut), 1);
      end else begin
        checkEq("R4 ack toggles per byte", int'(linkAck), int'(!prevAck));
      end
      prevAck = linkAck;
      @(negedge clk);
      pulseDone(8'h00, 1'b1);
    end
    checkEq("R4 frame line high at end", int'(linkTipN), 1);
    checkEq("R4 ack high at end", int'(linkAck), 1);
    checkEq("R4 direction in at end", int'(srDirOut), 0);
    checkEq("R4 ready again", int'(txReady), 1);
  endtask

  task automatic measureGuard(input string tag);
    int cnt;
    cnt = 0;
    while (!srLoad) begin
      @(negedge clk);
      cnt++;
    end
    checkEq(tag, cnt, GUARD_CYC);
  endtask

  initial begin
    int cnt;
    logic prev;
    // R1 reset state
    repeat (3) @(negedge clk);
    checkEq("R1 frame line", int'(linkTipN), 1);
    checkEq("R1 ack", int'(linkAck), 1);
    checkEq("R1 direction", int'(srDirOut), 0);
    checkEq("R1 txReady", int'(txReady), 0);
    checkEq("R1 rxValid/srLoad", int'({rxValid, srLoad}), 0);
    rstN = 1'b1;

    // R2 wake-up sequence
    curReq = "R2";
    while (linkTipN) @(negedge clk);
    checkEq("R2 not ready during wake-up", int'(txReady), 0);
    cnt = 0; while (linkAck) begin @(negedge clk); cnt++; end
    checkEq("R2 ack low spacing", cnt, SETTLE_CYC);
    cnt = 0; while (!linkTipN) begin @(negedge clk); cnt++; end
    checkEq("R2 frame line high spacing", cnt, SETTLE_CYC);
    cnt = 0; while (!linkAck) begin @(negedge clk); cnt++; end
    checkEq("R2 ack high spacing", cnt, SETTLE_CYC);
    checkEq("R2 ready after wake-up", int'(txReady), 1);

    // R3 / R4 plain write
    curReq = "R3";
    sendPacket('{8'hA1, 8'h11, 8'h22, 8'h00}, 3, 1'b1);
    servWrite(3);

    // R12 packet closed by depth
    curReq = "R12";
    sendPacket('{8'hB1, 8'hB2, 8'hB3, 8'hB4}, 4, 1'b0);
    servWrite(4);
    checkEq("R12 all bytes loaded", txQ.size(), 0);

    // R6 fake start
    curReq = "R6";
    @(negedge clk);
    pulseDone(8'hEE, 1'b1);
    checkEq("R6 fake start no byte", int'(rxValid), 0);
    checkEq("R6 fake start line stays", int'(linkTipN), 1);

    // R6 / R7 normal receive
    curReq = "R7";
    pushRx(0, 0, 0, 8'h01);
    pulseDone(8'h01, 1'b0);
    checkEq("R6 frame line low on receive", int'(linkTipN), 0);
    checkEq("R6 direction in on receive", int'(srDirOut), 0);
    checkEq("R6 ack unchanged on type byte", int'(linkAck), 1);
    for (int i = 0; i < 2; i++) begin
      prev = linkAck;
      pushRx(0, 0, 0, 8'h10 + 8'(i));
      pulseDone(8'h10 + 8'(i), 1'b0);
      checkEq("R7 ack toggles on receive", int'(linkAck), int'(!prev));
    end
    pushRx(0, 1, 3, 8'h30);
    pulseDone(8'h30, 1'b1);
    checkEq("R7 frame line high after last", int'(linkTipN), 1);
    checkEq("R7 ack high after last", int'(linkAck), 1);

    // R8 overflow
    curReq = "R8";
    pushRx(0, 0, 0, 8'h03);
    pulseDone(8'h03, 1'b0);
    for (int i = 0; i < 4; i++) begin
      pushRx(0, 0, 0, 8'h40 + 8'(i));
      pulseDone(8'h40 + 8'(i), 1'b0);
    end
    pushRx(1, 1, 5, 8'h4F);
    pulseDone(8'h4F, 1'b0);
    checkEq("R8 frame ended on overflow", int'(linkTipN), 1);
    linkReqN = 1'b1;

    // R5 blocked start
    curReq = "R5";
    linkReqN = 1'b0;
    sendPacket('{8'hB0, 8'h01, 8'h00, 8'h00}, 2, 1'b1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      checkEq("R5 no load while request low", int'(srLoad), 0);
    end
    checkEq("R5 frame line idle", int'(linkTipN), 1);
    linkReqN = 1'b1;
    servWrite(2);

    // R9 / R10 collision and replay
    curReq = "R9";
    sendPacket('{8'hC0, 8'h55, 8'h66, 8'h00}, 3, 1'b1);
    waitLoad(); @(negedge clk);
    pulseDone(8'h00, 1'b1);
    waitLoad(); @(negedge clk);
    pushRx(0, 0, 0, 8'h07);
    pulseDone(8'h07, 1'b0);
    checkEq("R9 frame line stays low", int'(linkTipN), 0);
    checkEq("R9 direction in", int'(srDirOut), 0);
    checkEq("R9 ack high", int'(linkAck), 1);
    checkEq("R9 not ready while pending", int'(txReady), 0);
    txQ.delete();
    txQ.push_back(8'hC0); txQ.push_back(8'h55); txQ.push_back(8'h66);
    curReq = "R10";
    pushRx(0, 1, 1, 8'h44);
    pulseDone(8'h44, 1'b1);
    measureGuard("R10 replay after guard");
    servWrite(3);

    // R11 guard back-off
    curReq = "R11";
    linkReqN = 1'b0;
    sendPacket('{8'hD0, 8'h77, 8'h00, 8'h00}, 2, 1'b1);
    pushRx(0, 0, 0, 8'h09);
    pulseDone(8'h09, 1'b0);
    pushRx(0, 1, 1, 8'h5A);
    pulseDone(8'h5A, 1'b1);
    linkReqN = 1'b0;
    cnt = 0;
    for (int i = 0; i < GUARD_CYC + 3; i++) begin
      @(negedge clk);
      if (srLoad) cnt++;
    end
    checkEq("R11 no write on back-off", cnt, 0);
    checkEq("R11 lines idle on back-off", int'({linkTipN, linkAck}), 3);
    pushRx(0, 0, 0, 8'h0B);
    pulseDone(8'h0B, 1'b0);
    pushRx(0, 1, 1, 8'h6C);
    pulseDone(8'h6C, 1'b1);
    measureGuard("R11 write after next frame");
    servWrite(2);

    repeat (3) @(negedge clk);
    checkEq("all expected loads seen", txQ.size(), 0);
    checkEq("all expected inbound bytes seen", rxQ.size(), 0);
    finishSim();
  end

endmodule